// File: doc/BRIEF.md
# Staged Transceiver Reset Sequencer

This block brings a four-lane serial transceiver out of reset in a fixed, timed order. A one-cycle start request captures a static configuration word and drives every transceiver control into its safe state at once: the four lane resets, the four lane power-downs and the two PLL resets, one for each lane pair. The block then lets the controls go in six steps, with an equal wait before the first step and after each one.

The release order runs power-down, then PLL reset, then lane reset, first for lanes 0 and 1 and then for lanes 2 and 3. A single shared counter times every wait, and its length in clock cycles is the parameter `WAIT_CYCLES`. After the last wait the block raises a done flag. The flag stays high until the next start. A start that arrives while a sequence is running restarts the sequence from the all-asserted state.

Top module: `serdes_rst_seq`

## Requirements
- R1: After reset, `ctrl_o[9:0]` is 10'h3FF (all controls asserted), `ctrl_o[15:10]` is 0 and `done_o` is 0.
- R2: One cycle after `start_i` is sampled high, `ctrl_o[9:0]` is 10'h3FF, `ctrl_o[15:10]` holds `cfg_i[15:10]` as sampled with the start, and `done_o` is 0.
- R3: Control bit positions are: lane resets [3:0] (bit n = lane n), lane power-downs [7:4] (bit 4+n = lane n), PLL reset for lanes 0/1 at bit 8 and for lanes 2/3 at bit 9. Releases happen in this order: power-down for lanes 0/1, PLL reset 0/1, lane reset 0/1, power-down for lanes 2/3, PLL reset 2/3, lane reset 2/3. This gives the held masks 3FF, 3CF, 2CF, 2CC, 20C, 00C, 000.
- R4: Each mask stage lasts exactly `WAIT_CYCLES` cycles. Stage k appears k*`WAIT_CYCLES` cycles after the first all-asserted cycle.
- R5: `done_o` rises 7*`WAIT_CYCLES` cycles after the start is sampled. It then stays high with `ctrl_o[9:0]` = 0 until the next start, which clears it in the following cycle.
- R6: A start sampled during a running sequence restarts it. Controls that were already released are asserted again, and the full timing of R4 and R5 begins again.
- R7: Changes on `cfg_i` while no start is sampled do not change `ctrl_o`.
- R8: `cfg_i[9:0]` never affects `ctrl_o[9:0]`. The sequence alone drives those bits.
- R9: A released control stays released until the next start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | One-cycle request to begin or restart the sequence |
| cfg_i | input | 16 | Static configuration; bits [15:10] pass to the output |
| ctrl_o | output | 16 | Transceiver control word |
| done_o | output | 1 | Sequence complete |

## Verification
The hardest situation to reach is a restart in the middle of a sequence, after some controls have already been released. The stimulus lets a sequence run into its third stage, so that both lane-0/1 power-downs and the lane-0/1 PLL reset are already released, and then pulses start. It checks that all ten controls come back on the next cycle, that the full seven-wait schedule runs again, and that done rises only at the end of that new schedule.

// File: rtl/serdes_rst_pkg.sv
package serdes_rst_pkg;
  localparam int NUM_CTRL   = 10;
  localparam int NUM_STAGES = 6;
  localparam int STAGE_W    = 3;
  localparam int RST_LSB    = 0;
  localparam int PD_LSB     = 4;
  localparam int PLL_LSB    = 8;

  // Held control mask after `stage` releases have taken place
  function automatic logic [NUM_CTRL-1:0] held_mask(input logic [STAGE_W-1:0] stage);
    logic [NUM_CTRL-1:0] m;
    m = '1;
    for (int i = 1; i <= NUM_STAGES; i++) begin
      if (i <= int'(stage)) begin
        int pair;
        int kind;
        pair = (i - 1) / 3;
        kind = (i - 1) % 3;
        case (kind)
          0: begin
            m[PD_LSB + 2*pair]     = 1'b0;
            m[PD_LSB + 2*pair + 1] = 1'b0;
          end
          1: m[PLL_LSB + pair] = 1'b0;
          default: begin
            m[RST_LSB + 2*pair]     = 1'b0;
            m[RST_LSB + 2*pair + 1] = 1'b0;
          end
        endcase
      end
    end
    return m;
  endfunction
endpackage

// File: rtl/seq_wait_timer.sv
module seq_wait_timer #(
  parameter int WAIT_CYCLES = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic expire_o
);
  localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WAIT_CYCLES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (clear_i)           cnt_q <= '0;
    else if (run_i && expire_o) cnt_q <= '0;
    else if (run_i)             cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = run_i && (cnt_q == LAST);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);
endmodule

// File: rtl/seq_stage_decode.sv
module seq_stage_decode
  import serdes_rst_pkg::*;
(
  input  logic [STAGE_W-1:0]  stage_i,
  output logic [NUM_CTRL-1:0] mask_o
);
  always_comb mask_o = held_mask(stage_i);
endmodule

// File: rtl/serdes_rst_seq.sv
module serdes_rst_seq
  import serdes_rst_pkg::*;
#(
  parameter int WAIT_CYCLES = 3000,
  parameter int CTRL_W      = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [CTRL_W-1:0] cfg_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              done_o
);
  localparam logic [STAGE_W-1:0] LAST_STAGE = STAGE_W'(NUM_STAGES);
  localparam logic [CTRL_W-1:0]  CTRL_MASK  = CTRL_W'({NUM_CTRL{1'b1}});

  logic [STAGE_W-1:0]  stage_q;
  logic                busy_q;
  logic                done_q;
  logic [CTRL_W-1:0]   cfg_q;
  logic                wait_expire;
  logic [NUM_CTRL-1:0] held;
  logic [CTRL_W-1:0]   held_ctrl;

  seq_wait_timer #(.WAIT_CYCLES(WAIT_CYCLES)) timer_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (start_i),
    .run_i    (busy_q),
    .expire_o (wait_expire)
  );

  seq_stage_decode decode_i (
    .stage_i (stage_q),
    .mask_o  (held)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      cfg_q   <= '0;
    end else if (start_i) begin
      stage_q <= '0;
      busy_q  <= 1'b1;
      done_q  <= 1'b0;
      cfg_q   <= cfg_i;
    end else if (wait_expire) begin
      if (stage_q == LAST_STAGE) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        stage_q <= stage_q + 1'b1;
      end
    end
  end

  assign held_ctrl = CTRL_W'(held);
  assign ctrl_o    = (cfg_q & ~CTRL_MASK) | held_ctrl;
  assign done_o    = done_q;

  // R2
  start_asserts_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> ((ctrl_o & CTRL_MASK) == CTRL_MASK) && !done_o);
  // R5
  done_all_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ((ctrl_o & CTRL_MASK) == '0));
  // R5
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && !start_i) |=> done_o);
  // R9
  no_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ((ctrl_o & CTRL_MASK & ~$past(ctrl_o)) == '0));
  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> ((ctrl_o & ~CTRL_MASK) == ($past(ctrl_o) & ~CTRL_MASK)));
  // R3
  stage_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stage_q <= LAST_STAGE);
endmodule

// File: tb/serdes_rst_seq_tb_top.sv
module serdes_rst_seq_tb_top;
  localparam int W = 4;
  localparam logic [9:0] EXP_MASK [7] =
    '{10'h3FF, 10'h3CF, 10'h2CF, 10'h2CC, 10'h20C, 10'h00C, 10'h000};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] cfg_i = '0;
  logic [15:0] ctrl_o;
  logic        done_o;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  serdes_rst_seq #(.WAIT_CYCLES(W), .CTRL_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cfg_i(cfg_i),
    .ctrl_o(ctrl_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(posedge clk);
    #1 start_i = 1'b0;
  endtask

  // Walks all seven stages from just after a sampled start
  task automatic walk(input logic [15:0] hi, input string tag);
    for (int k = 0; k < 7; k++) begin
      chk({tag, " R3 stage mask"}, 32'(ctrl_o), 32'(hi | 16'(EXP_MASK[k])));
      step(W - 1);
      chk({tag, " R4 stage end mask"}, 32'(ctrl_o), 32'(hi | 16'(EXP_MASK[k])));
      chk({tag, " R5 done low"}, 32'(done_o), 32'd0);
      step(1);
    end
    chk({tag, " R5 done high"}, 32'(done_o), 32'd1);
    chk({tag, " R5 all released"}, 32'(ctrl_o), 32'(hi));
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset ctrl", 32'(ctrl_o), 32'h03FF);
    chk("R1 reset done", 32'(done_o), 32'd0);

    // Control-position config bits set to probe R8
    cfg_i = 16'hA955;
    pulse_start();
    chk("R2 start ctrl", 32'(ctrl_o), 32'hABFF);
    cfg_i = 16'h0000;
    walk(16'hA800, "run1 R8");
    step(10);
    chk("R5 done sticky", 32'(done_o), 32'd1);
    chk("R7 cfg change ignored", 32'(ctrl_o), 32'hA800);

    // R6: restart in the middle of stage 2
    cfg_i = 16'h5400;
    pulse_start();
    chk("R5 done clears on start", 32'(done_o), 32'd0);
    step(2 * W + 1);
    chk("R6 mid-run stage2", 32'(ctrl_o), 32'h56CF);
    pulse_start();
    walk(16'h5400, "R6 restart");

    finished = 1'b1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule